// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This block divides one 32-bit operand by another over several clock cycles. It handles either two's-complement or unsigned operands, chosen per operation. A one-cycle start pulse launches an operation. A one-cycle done pulse marks the cycle in which the quotient output carries the new result. The quotient stays on the output until the next result replaces it.

A zero divisor takes a short path. The quotient is forced to zero and the operation completes at once. A sticky zero-divide status flag is set, and it stays set until a later operation with a non-zero divisor is accepted. A zero divisor can also raise a one-cycle exception request toward the processor's trap logic. It does so only when the global exception-enable input is high and the per-exception mask input is low. When the request is raised, a dedicated cause code is written into the cause register output at the same time.

A non-zero divisor runs a restoring shift-and-subtract loop that produces one quotient bit per cycle. The unit ignores start pulses while the loop is running.

Top module: `iter_divider`

## Requirements
- R1: A start accepted with a divisor of 0 sets quotient_o to 0 and pulses done_o in the cycle after the accepting edge. busy_o is never raised for such an operation.
- R2: A start accepted with a divisor of 0 sets dz_flag_o in the next cycle. The flag then stays at 1 through any number of further zero-divisor operations.
- R3: A start accepted with a non-zero divisor clears dz_flag_o in the next cycle.
- R4: When a zero-divisor start is accepted with exc_en_i = 1 and exc_mask_i = 0, exc_req_o is 1 for exactly the next cycle. In that same cycle exc_cause_o is updated to CAUSE_CODE (default 5'd5).
- R5: When a zero-divisor start is accepted with exc_en_i = 0 or exc_mask_i = 1, exc_req_o stays 0 and exc_cause_o keeps its previous value.
- R6: A start accepted with a non-zero divisor raises busy_o from the next cycle. done_o pulses for one cycle, with busy_o low, exactly 32 cycles after the accepting edge.
- R7: With signed_i = 0, the quotient is the unsigned floor of dividend_i / divisor_i.
- R8: With signed_i = 1, the operands are two's-complement and the quotient is truncated toward zero. 0x80000000 / 0xFFFFFFFF returns 0x80000000 and raises no exception.
- R9: A start pulse while busy_o is 1 has no effect on the running result, its timing, dz_flag_o, exc_req_o or exc_cause_o.
- R10: quotient_o changes only in a cycle where done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse; accepted only when busy_o is 0 |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| exc_en_i | input | 1 | Global exception enable |
| exc_mask_i | input | 1 | 1 suppresses the zero-divide exception |
| busy_o | output | 1 | Iteration loop running |
| done_o | output | 1 | One-cycle result strobe |
| quotient_o | output | 32 | Quotient of the latest completed operation |
| dz_flag_o | output | 1 | Sticky zero-divide status |
| exc_req_o | output | 1 | One-cycle exception request |
| exc_cause_o | output | 5 | Cause register, written when an exception is raised |

## Verification
Every output is registered, so its timing is fixed. A zero-divisor operation shows its done pulse, zero quotient, status flag, request and cause one cycle after the accepting edge. A non-zero operation shows busy one cycle after that edge, a cleared flag at the same point, and its done pulse and quotient 32 cycles after it. The bench keeps a behavioural model that advances on each rising edge from the same inputs. It compares all outputs at every falling edge, so each result is checked in exactly the cycle it is due, and stray early or late values are caught as well.

// File: rtl/iter_div_pkg.sv
package iter_div_pkg;

    localparam int DATA_W  = 32;
    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] DZ_CAUSE = 5'd5;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } div_mode_e;

    typedef struct packed {
        logic               flag;
        logic               req;
        logic [CAUSE_W-1:0] cause;
    } dz_state_t;

    function automatic logic trap_allowed(logic enable, logic mask);
        return enable && !mask;
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import iter_div_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] a_mag_o,
    output logic [W-1:0] b_mag_o,
    output logic         neg_o
);
    div_mode_e mode;
    logic      a_neg;
    logic      b_neg;

    always_comb begin
        mode    = div_mode_e'(signed_i);
        a_neg   = (mode == MODE_SIGNED) && dividend_i[W-1];
        b_neg   = (mode == MODE_SIGNED) && divisor_i[W-1];
        a_mag_o = a_neg ? ((~dividend_i) + W'(1)) : dividend_i;
        b_mag_o = b_neg ? ((~divisor_i) + W'(1)) : divisor_i;
        neg_o   = a_neg ^ b_neg;
    end
endmodule

// File: rtl/div_shift_core.sv
module div_shift_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] a_mag_i,
    input  logic [W-1:0] b_mag_i,
    input  logic         neg_i,
    output logic         busy_o,
    output logic         last_o,
    output logic [W-1:0] result_o
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

    logic [W-1:0]     rem_q, quo_q, div_q;
    logic             neg_q, busy_q;
    logic [CNT_W-1:0] cnt_q;

    logic [W:0]   shifted, trial;
    logic         fits;
    logic [W-1:0] rem_n, quo_n;

    always_comb begin
        shifted  = {rem_q, quo_q[W-1]};
        trial    = shifted - {1'b0, div_q};
        fits     = !trial[W];
        rem_n    = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_n    = {quo_q[W-2:0], fits};
        result_o = neg_q ? ((~quo_n) + W'(1)) : quo_n;
        last_o   = busy_q && (cnt_q == LAST_CNT);
        busy_o   = busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            div_q  <= '0;
            neg_q  <= 1'b0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == LAST_CNT) begin
                busy_q <= 1'b0;
            end
        end else if (load_i) begin
            rem_q  <= '0;
            quo_q  <= a_mag_i;
            div_q  <= b_mag_i;
            neg_q  <= neg_i;
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end
    end
endmodule

// File: rtl/div_zero_trap.sv
module div_zero_trap
    import iter_div_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] CAUSE_CODE = DZ_CAUSE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               zero_acc_i,
    input  logic               nz_acc_i,
    input  logic               exc_en_i,
    input  logic               exc_mask_i,
    output logic               flag_o,
    output logic               req_o,
    output logic [CAUSE_W-1:0] cause_o
);
    dz_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.req <= 1'b0;
            if (zero_acc_i) begin
                st_q.flag <= 1'b1;
                if (trap_allowed(exc_en_i, exc_mask_i)) begin
                    st_q.req   <= 1'b1;
                    st_q.cause <= CAUSE_CODE;
                end
            end else if (nz_acc_i) begin
                st_q.flag <= 1'b0;
            end
        end
    end

    assign flag_o  = st_q.flag;
    assign req_o   = st_q.req;
    assign cause_o = st_q.cause;
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import iter_div_pkg::*;
#(
    parameter int W = DATA_W,
    parameter logic [CAUSE_W-1:0] CAUSE_CODE = DZ_CAUSE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               signed_i,
    input  logic [W-1:0]       dividend_i,
    input  logic [W-1:0]       divisor_i,
    input  logic               exc_en_i,
    input  logic               exc_mask_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [W-1:0]       quotient_o,
    output logic               dz_flag_o,
    output logic               exc_req_o,
    output logic [CAUSE_W-1:0] exc_cause_o
);
    logic         accept, zero_acc, nz_acc;
    logic [W-1:0] a_mag, b_mag, core_res;
    logic         neg, core_busy, core_last;
    logic [W-1:0] quo_q;
    logic         done_q;

    always_comb begin
        accept   = start_i && !core_busy;
        zero_acc = accept && (divisor_i == '0);
        nz_acc   = accept && (divisor_i != '0);
    end

    div_operand_prep #(.W(W)) u_prep (
        .signed_i   (signed_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .a_mag_o    (a_mag),
        .b_mag_o    (b_mag),
        .neg_o      (neg)
    );

    div_shift_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load_i   (nz_acc),
        .a_mag_i  (a_mag),
        .b_mag_i  (b_mag),
        .neg_i    (neg),
        .busy_o   (core_busy),
        .last_o   (core_last),
        .result_o (core_res)
    );

    div_zero_trap #(.CAUSE_CODE(CAUSE_CODE)) u_trap (
        .clk        (clk),
        .rst        (rst),
        .zero_acc_i (zero_acc),
        .nz_acc_i   (nz_acc),
        .exc_en_i   (exc_en_i),
        .exc_mask_i (exc_mask_i),
        .flag_o     (dz_flag_o),
        .req_o      (exc_req_o),
        .cause_o    (exc_cause_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= zero_acc || core_last;
            if (zero_acc) begin
                quo_q <= '0;
            end else if (core_last) begin
                quo_q <= core_res;
            end
        end
    end

    assign busy_o     = core_busy;
    assign done_o     = done_q;
    assign quotient_o = quo_q;
endmodule

// File: rtl/iter_divider_checker.sv
module iter_divider_checker
    import iter_div_pkg::*;
#(
    parameter int W = DATA_W,
    parameter logic [CAUSE_W-1:0] CAUSE_CODE = DZ_CAUSE
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic [W-1:0]       divisor_i,
    input logic               exc_en_i,
    input logic               exc_mask_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [W-1:0]       quotient_o,
    input logic               dz_flag_o,
    input logic               exc_req_o,
    input logic [CAUSE_W-1:0] exc_cause_o
);
    localparam int RC_W = $clog2(W) + 2;

    logic zacc, nzacc;
    assign zacc  = start_i && !busy_o && (divisor_i == '0);
    assign nzacc = start_i && !busy_o && (divisor_i != '0);

    logic            running;
    logic [RC_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            run_cnt <= '0;
        end else if (nzacc) begin
            running <= 1'b1;
            run_cnt <= '0;
        end else if (running) begin
            run_cnt <= run_cnt + RC_W'(1);
            if (done_o) running <= 1'b0;
        end
    end

    AST_ZERO_QUOT: assert property (@(posedge clk) disable iff (rst)
        zacc |=> (done_o && quotient_o == '0 && !busy_o)); // R1
    AST_DZ_SET: assert property (@(posedge clk) disable iff (rst)
        zacc |=> dz_flag_o); // R2
    AST_DZ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        nzacc |=> (!dz_flag_o && busy_o)); // R3
    AST_EXC_RAISE: assert property (@(posedge clk) disable iff (rst)
        (zacc && exc_en_i && !exc_mask_i) |=> (exc_req_o && exc_cause_o == CAUSE_CODE)); // R4
    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (rst)
        exc_req_o |-> (dz_flag_o && exc_cause_o == CAUSE_CODE)); // R4
    AST_EXC_MASKED: assert property (@(posedge clk) disable iff (rst)
        (zacc && (!exc_en_i || exc_mask_i)) |=> (!exc_req_o && $stable(exc_cause_o))); // R5
    AST_RUN_LATENCY: assert property (@(posedge clk) disable iff (rst)
        running |-> (done_o == (run_cnt == RC_W'(W)))); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R6
    AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ($stable(dz_flag_o) && !exc_req_o)); // R9
    AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(quotient_o) || $past(rst)); // R10
endmodule

bind iter_divider iter_divider_checker #(.W(W), .CAUSE_CODE(CAUSE_CODE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .divisor_i   (divisor_i),
    .exc_en_i    (exc_en_i),
    .exc_mask_i  (exc_mask_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .dz_flag_o   (dz_flag_o),
    .exc_req_o   (exc_req_o),
    .exc_cause_o (exc_cause_o)
);

// File: tb/iter_divider_tb.sv
module iter_divider_tb;
    localparam int W = 32;
    localparam logic [4:0] CAUSE = 5'd5;
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, sgn = 1'b0, en = 1'b0, msk = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic busy, done, dzf, exc;
    logic [W-1:0] quo;
    logic [4:0] cause;

    always #4 clk = ~clk;

    iter_divider u_dut (
        .clk(clk), .rst(rst), .start_i(start), .signed_i(sgn),
        .dividend_i(a), .divisor_i(b), .exc_en_i(en), .exc_mask_i(msk),
        .busy_o(busy), .done_o(done), .quotient_o(quo),
        .dz_flag_o(dzf), .exc_req_o(exc), .exc_cause_o(cause)
    );

    int checks = 0, fails = 0, cycles = 0;
    bit seen_edge = 0;

    // behavioural reference state
    bit m_busy = 0, m_done = 0, m_flag = 0, m_exc = 0;
    int m_cnt = 0;
    logic [W-1:0] m_q = '0, m_pend = '0;
    logic [4:0] m_cause = '0;

    function automatic logic [W-1:0] ref_div(logic [W-1:0] x, logic [W-1:0] y, bit s);
        longint sx, sy;
        if (!s) return x / y;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        return W'(sx / sy);
    endfunction

    always @(posedge clk) begin
        seen_edge <= 1;
        cycles <= cycles + 1;
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_flag <= 0; m_exc <= 0;
            m_cnt <= 0; m_q <= '0; m_cause <= '0;
        end else begin
            m_done <= 0;
            m_exc  <= 0;
            if (m_busy) begin
                m_cnt <= m_cnt + 1;
                if (m_cnt == W - 1) begin
                    m_busy <= 0; m_done <= 1; m_q <= m_pend;
                end
            end else if (start) begin
                if (b == '0) begin
                    m_done <= 1; m_q <= '0; m_flag <= 1;
                    if (en && !msk) begin m_exc <= 1; m_cause <= CAUSE; end
                end else begin
                    m_busy <= 1; m_cnt <= 0; m_flag <= 0;
                    m_pend <= ref_div(a, b, sgn);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (seen_edge) begin
            check(done == m_done, "R1 R6 done", W'(done), W'(m_done));
            check(busy == m_busy, "R6 R9 busy", W'(busy), W'(m_busy));
            check(quo == m_q, "R1 R7 R8 R10 quotient", quo, m_q);
            check(dzf == m_flag, "R2 R3 flag", W'(dzf), W'(m_flag));
            check(exc == m_exc, "R4 R5 R9 exc_req", W'(exc), W'(m_exc));
            check(cause == m_cause, "R4 R5 cause", W'(cause), W'(m_cause));
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > LIMIT) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
            finish_run();
        end
    end

    task automatic launch(input logic [W-1:0] x, input logic [W-1:0] y, input bit s, input bit e, input bit m);
        @(negedge clk);
        a = x; b = y; sgn = s; en = e; msk = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input bit s, input bit e, input bit m);
        launch(x, y, s, e, m);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state covered by the per-cycle compare
        @(negedge clk);
        check(quo == '0 && !dzf && !busy, "R10 reset state", quo, '0);
        // R7 unsigned
        run_op(32'd100, 32'd7, 0, 1, 0);
        check(quo == 32'd14, "R7 100/7", quo, 32'd14);
        run_op(32'hFFFF_FFFF, 32'd1, 0, 1, 0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 0);
        run_op(32'd5, 32'd10, 0, 1, 0);
        // R8 signed
        run_op(-32'sd7, 32'd2, 1, 1, 0);
        check(quo == 32'hFFFF_FFFD, "R8 -7/2", quo, 32'hFFFF_FFFD);
        run_op(32'd7, -32'sd2, 1, 1, 0);
        run_op(-32'sd7, -32'sd2, 1, 1, 0);
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0);
        check(quo == 32'h8000_0000 && !exc, "R8 overflow case", quo, 32'h8000_0000);
        run_op(32'h8000_0000, 32'd1, 1, 1, 0);
        // R1 R4 zero divisor, trap raised
        run_op(32'd55, 32'd0, 0, 1, 0);
        check(dzf == 1'b1, "R2 flag set", W'(dzf), 1);
        // R2 sticky, R5 disabled and masked
        run_op(32'd9, 32'd0, 1, 0, 0);
        run_op(32'd9, 32'd0, 0, 1, 1);
        check(dzf == 1'b1 && cause == CAUSE, "R2 R5 sticky", W'(dzf), 1);
        // R3 clear
        run_op(32'd9, 32'd3, 0, 1, 0);
        check(dzf == 1'b0, "R3 flag cleared", W'(dzf), 0);
        // back-to-back zero starts
        launch(32'd1, 32'd0, 0, 1, 0);
        launch(32'd2, 32'd0, 0, 1, 0);
        run_op(32'd3, 32'd0, 0, 0, 0);
        // R9 start while busy
        launch(32'd1000, 32'd10, 0, 1, 0);
        repeat (5) @(negedge clk);
        a = 32'd7; b = 32'd0; en = 1; msk = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!exc && !dzf, "R9 ignored start", W'(exc), 0);
        while (busy) @(negedge clk);
        @(negedge clk);
        check(quo == 32'd100, "R9 result intact", quo, 32'd100);
        // mixed patterns
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] x, y;
            x = $urandom;
            y = (i % 7 == 3) ? '0 : ($urandom >> (i % 24));
            run_op(x, y, i[0], i[1], i[2]);
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule